// File: doc/BRIEF.md
# MSI Capability Register Shadow

This block sits on the configuration-space write path of a function that exposes an MSI capability at a fixed location. It watches every write and decides whether the write lands inside the capability window. If it does, the block updates its own copies of the message control word, the 64-bit message address and the 16-bit message data. The capability location and its length are elaboration parameters. The length selects the field layout: 0x0A gives the 32-bit address layout, 0x0E gives the 64-bit layout, and 0x18 gives the 64-bit layout with masking.

A write carries a byte address, a byte count of 1, 2, 4 or 8, and byte-packed little-endian data. Byte k of the write sits in `wrData[8k+7:8k]`. The write is forwarded unchanged on a downstream port in the same cycle, whether or not it touches the capability.

When a control write changes the MSI enable bit, the block raises a single-cycle event. The enable event marks a 0 to 1 change and the disable event marks a 1 to 0 change. Logic that programs or tears down interrupt delivery reacts to these events.

Top module: `msi_cap_shadow`

## Requirements
- R1: A write is a capability access only if its start address is at least the capability offset, its start plus its byte count is at most the offset plus the length, and its byte count is at most the length. Any other write leaves every shadow field unchanged and raises no event.
- R2: A 2-byte capability access at relative offset 2 replaces the control word, visible on `msiCtrl` one cycle after the write.
- R3: Bit 0 of the control word is the enable. When a control write takes it from 0 to 1, `enablePulse` is high for exactly the one cycle after the write. When a control write takes it from 1 to 0, `disablePulse` is high for that one cycle instead. Every other write leaves both low.
- R4: In the 32-bit layout (length 0x0A), a 4-byte access at relative offset 4 loads the low 32 address bits and clears the upper 32 bits.
- R5: In both 64-bit layouts, a 4-byte access at relative offset 4 replaces only address bits 31:0, and a 4-byte access at relative offset 8 replaces only address bits 63:32.
- R6: In both 64-bit layouts, an 8-byte access at relative offset 4 replaces the whole 64-bit address.
- R7: The message data sits at relative offset 8 in the 32-bit layout and at relative offset 0x0C in both 64-bit layouts. Only a 2-byte access at that offset updates it.
- R8: Write data is little-endian: the byte at the lowest address lands in the least significant bits of the target field.
- R9: A capability access that matches none of the cases in R2 to R7 changes no shadow field and raises no event.
- R10: Every write appears on the forward port in the same cycle, with its original valid, address, length and data.
- R11: Reset clears control, address, data and both events to zero, so MSI starts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrLen | input | 4 | Byte count: 1, 2, 4 or 8 |
| wrData | input | 64 | Byte-packed little-endian write data |
| fwdValid | output | 1 | Forwarded write strobe |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdLen | output | 4 | Forwarded byte count |
| fwdData | output | 64 | Forwarded data |
| msiCtrl | output | 16 | Shadow control word |
| msiAddr | output | 64 | Shadow message address |
| msiData | output | 16 | Shadow message data |
| enablePulse | output | 1 | One-cycle enable event |
| disablePulse | output | 1 | One-cycle disable event |

## Verification
The assertions assume `wrLen` takes only the values 1, 2, 4 and 8. They also assume the address plus length does not wrap the address space. The bench sweeps start addresses from a few bytes below the window to a few bytes above it, using only those four lengths and keeping all addresses far from the top of the address range. Three instances with the three legal layouts share the same input bus, so every write is judged against all three layouts at once. A bench model built from the requirements supplies the expected values.

// File: rtl/msi_shadow_pkg.sv
package msi_shadow_pkg;
  typedef struct packed {
    logic ctlWr;
    logic addrLoWr;
    logic addrHiClr;
    logic addrHiWr;
    logic addrFullWr;
    logic dataWr;
    logic enEvt;
    logic disEvt;
  } shadowStrobe_t;

  localparam int unsigned LEN_32BIT = 10;
endpackage

// File: rtl/msi_shadow_ctrl.sv
module msi_shadow_ctrl
  import msi_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CAP_OFFSET = 64,
  parameter int unsigned CAP_LEN    = 24
) (
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrLen,
  input  logic              newEnable,
  input  logic              curEnable,
  output shadowStrobe_t     strobe
);
  localparam logic [ADDR_W:0]   capStart = (ADDR_W+1)'(CAP_OFFSET);
  localparam logic [ADDR_W:0]   capEnd   = (ADDR_W+1)'(CAP_OFFSET + CAP_LEN);
  localparam logic [ADDR_W-1:0] capBase  = ADDR_W'(CAP_OFFSET);
  localparam logic [5:0]        capLen   = 6'(CAP_LEN);
  localparam bit                is32     = (CAP_LEN == LEN_32BIT);
  localparam logic [ADDR_W-1:0] dataRel  = is32 ? ADDR_W'(8) : ADDR_W'(12);

  logic [ADDR_W:0]   endAddr;
  logic [ADDR_W-1:0] rel;
  logic              inRange;
  logic              len2, len4, len8;

  always_comb begin
    endAddr = {1'b0, wrAddr} + (ADDR_W+1)'(wrLen);
    rel     = wrAddr - capBase;
    inRange = wrValid && ({1'b0, wrAddr} >= capStart) && (endAddr <= capEnd)
              && ({2'b00, wrLen} <= capLen);
    len2    = (wrLen == 4'd2);
    len4    = (wrLen == 4'd4);
    len8    = (wrLen == 4'd8);
  end

  always_comb begin
    strobe            = '0;
    strobe.ctlWr      = inRange && len2 && (rel == ADDR_W'(2));
    strobe.addrLoWr   = inRange && len4 && (rel == ADDR_W'(4));
    strobe.addrHiClr  = strobe.addrLoWr && is32;
    strobe.addrHiWr   = inRange && len4 && (rel == ADDR_W'(8)) && !is32;
    strobe.addrFullWr = inRange && len8 && (rel == ADDR_W'(4)) && !is32;
    strobe.dataWr     = inRange && len2 && (rel == dataRel);
    strobe.enEvt      = strobe.ctlWr && !curEnable && newEnable;
    strobe.disEvt     = strobe.ctlWr && curEnable && !newEnable;
  end
endmodule

// File: rtl/msi_shadow_dp.sv
module msi_shadow_dp
  import msi_shadow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  shadowStrobe_t strobe,
  input  logic [63:0]   wrData,
  output logic [15:0]   ctlReg,
  output logic [63:0]   addrReg,
  output logic [15:0]   dataReg,
  output logic          enPulse,
  output logic          disPulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlReg   <= '0;
      addrReg  <= '0;
      dataReg  <= '0;
      enPulse  <= 1'b0;
      disPulse <= 1'b0;
    end else begin
      enPulse  <= strobe.enEvt;
      disPulse <= strobe.disEvt;
      if (strobe.ctlWr)      ctlReg <= wrData[15:0];
      if (strobe.dataWr)     dataReg <= wrData[15:0];
      if (strobe.addrFullWr) addrReg <= wrData;
      if (strobe.addrLoWr)   addrReg[31:0] <= wrData[31:0];
      if (strobe.addrHiClr)  addrReg[63:32] <= '0;
      if (strobe.addrHiWr)   addrReg[63:32] <= wrData[31:0];
    end
  end
endmodule

// File: rtl/msi_cap_shadow.sv
module msi_cap_shadow
  import msi_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CAP_OFFSET = 64,
  parameter int unsigned CAP_LEN    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrLen,
  input  logic [63:0]       wrData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [3:0]        fwdLen,
  output logic [63:0]       fwdData,
  output logic [15:0]       msiCtrl,
  output logic [63:0]       msiAddr,
  output logic [15:0]       msiData,
  output logic              enablePulse,
  output logic              disablePulse
);
  shadowStrobe_t strobe;

  assign fwdValid = wrValid;
  assign fwdAddr  = wrAddr;
  assign fwdLen   = wrLen;
  assign fwdData  = wrData;

  msi_shadow_ctrl #(
    .ADDR_W(ADDR_W), .CAP_OFFSET(CAP_OFFSET), .CAP_LEN(CAP_LEN)
  ) uCtrl (
    .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
    .newEnable(wrData[0]), .curEnable(msiCtrl[0]), .strobe(strobe)
  );

  msi_shadow_dp uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .ctlReg(msiCtrl), .addrReg(msiAddr), .dataReg(msiData),
    .enPulse(enablePulse), .disPulse(disablePulse)
  );
endmodule

// File: rtl/msi_shadow_chk.sv
module msi_shadow_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CAP_OFFSET = 64,
  parameter int unsigned CAP_LEN    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [3:0]        wrLen,
  input logic [15:0]       msiCtrl,
  input logic [63:0]       msiAddr,
  input logic [15:0]       msiData,
  input logic              enablePulse,
  input logic              disablePulse
);
  logic outside;
  logic layout32;
  assign outside  = !wrValid || (32'(wrAddr) < CAP_OFFSET)
                    || (32'(wrAddr) + 32'(wrLen) > CAP_OFFSET + CAP_LEN);
  assign layout32 = (CAP_LEN == 10);

  a_r1_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
    outside |=> ($stable(msiCtrl) && $stable(msiAddr) && $stable(msiData)
                 && !enablePulse && !disablePulse));

  a_r3_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(enablePulse && disablePulse));

  a_r3_enable_edge: assert property (@(posedge clk) disable iff (!rst_n)
    enablePulse |-> (msiCtrl[0] && !$past(msiCtrl[0])));

  a_r3_disable_edge: assert property (@(posedge clk) disable iff (!rst_n)
    disablePulse |-> (!msiCtrl[0] && $past(msiCtrl[0])));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    layout32 |-> (msiAddr[63:32] == 32'h0));

  a_r7_data_len2_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrLen != 4'd2) |=> $stable(msiData));
endmodule

bind msi_cap_shadow msi_shadow_chk #(
  .ADDR_W(ADDR_W), .CAP_OFFSET(CAP_OFFSET), .CAP_LEN(CAP_LEN)
) uChk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
  .msiCtrl(msiCtrl), .msiAddr(msiAddr), .msiData(msiData),
  .enablePulse(enablePulse), .disablePulse(disablePulse)
);

// File: tb/sim_msi_cap_shadow.sv
module sim_msi_cap_shadow;
  localparam int unsigned AW  = 12;
  localparam int unsigned OFF = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [3:0] wrLen = 4'd1;
  logic [63:0] wrData = '0;

  logic [15:0] oCtl [3];
  logic [63:0] oAddr [3];
  logic [15:0] oData [3];
  logic oEn [3];
  logic oDis [3];
  logic fV [3];
  logic [AW-1:0] fA [3];
  logic [3:0] fL [3];
  logic [63:0] fD [3];

  int unsigned capLens [3] = '{24, 10, 14};
  logic [15:0] mCtl [3];
  logic [63:0] mAddr [3];
  logic [15:0] mData [3];
  logic mEn [3];
  logic mDis [3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msi_cap_shadow #(.ADDR_W(AW), .CAP_OFFSET(OFF), .CAP_LEN(24)) u0 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
    .wrData(wrData), .fwdValid(fV[0]), .fwdAddr(fA[0]), .fwdLen(fL[0]),
    .fwdData(fD[0]), .msiCtrl(oCtl[0]), .msiAddr(oAddr[0]), .msiData(oData[0]),
    .enablePulse(oEn[0]), .disablePulse(oDis[0]));
  msi_cap_shadow #(.ADDR_W(AW), .CAP_OFFSET(OFF), .CAP_LEN(10)) u1 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
    .wrData(wrData), .fwdValid(fV[1]), .fwdAddr(fA[1]), .fwdLen(fL[1]),
    .fwdData(fD[1]), .msiCtrl(oCtl[1]), .msiAddr(oAddr[1]), .msiData(oData[1]),
    .enablePulse(oEn[1]), .disablePulse(oDis[1]));
  msi_cap_shadow #(.ADDR_W(AW), .CAP_OFFSET(OFF), .CAP_LEN(14)) u2 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
    .wrData(wrData), .fwdValid(fV[2]), .fwdAddr(fA[2]), .fwdLen(fL[2]),
    .fwdData(fD[2]), .msiCtrl(oCtl[2]), .msiAddr(oAddr[2]), .msiData(oData[2]),
    .enablePulse(oEn[2]), .disablePulse(oDis[2]));

  task automatic chk(input string req, input int k, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst=%0d actual=%h expected=%h", req, k, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk({tag, " R2 ctrl"}, k, 64'(oCtl[k]), 64'(mCtl[k]));
      chk({tag, " R5 addr"}, k, oAddr[k], mAddr[k]);
      chk({tag, " R7 data"}, k, 64'(oData[k]), 64'(mData[k]));
      chk({tag, " R3 enable"}, k, 64'(oEn[k]), 64'(mEn[k]));
      chk({tag, " R3 disable"}, k, 64'(oDis[k]), 64'(mDis[k]));
    end
  endtask

  // Bench model derived from R1..R9
  task automatic model(input int unsigned a, input int unsigned n,
                       input logic [63:0] d);
    for (int k = 0; k < 3; k++) begin
      int unsigned cl = capLens[k];
      int unsigned rel = a - OFF;
      bit is32 = (cl == 10);
      int unsigned dOff = is32 ? 8 : 12;
      bit inR = (a >= OFF) && (a + n <= OFF + cl) && (n <= cl);
      mEn[k] = 1'b0;
      mDis[k] = 1'b0;
      if (inR) begin
        if (n == 2 && rel == 2) begin
          mEn[k] = !mCtl[k][0] && d[0];
          mDis[k] = mCtl[k][0] && !d[0];
          mCtl[k] = d[15:0];
        end else if (n == 4 && rel == 4) begin
          if (is32) mAddr[k] = {32'h0, d[31:0]};
          else mAddr[k][31:0] = d[31:0];
        end else if (n == 4 && rel == 8 && !is32) begin
          mAddr[k][63:32] = d[31:0];
        end else if (n == 8 && rel == 4 && !is32) begin
          mAddr[k] = d;
        end else if (n == 2 && rel == dOff) begin
          mData[k] = d[15:0];
        end
      end
    end
  endtask

  task automatic doWrite(input int unsigned a, input int unsigned n,
                         input logic [63:0] d, input string tag);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr = AW'(a);
    wrLen = 4'(n);
    wrData = d;
    #1;
    chk("R10 fwd valid", 0, 64'(fV[0]), 64'd1);
    chk("R10 fwd addr", 0, 64'(fA[0]), 64'(a));
    chk("R10 fwd len", 0, 64'(fL[0]), 64'(n));
    chk("R10 fwd data", 0, fD[0], d);
    model(a, n, d);
    @(negedge clk);
    wrValid = 1'b0;
    checkAll(tag);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R3 one-cycle enable", k, 64'(oEn[k]), 64'd0);
      chk("R3 one-cycle disable", k, 64'(oDis[k]), 64'd0);
      mEn[k] = 1'b0;
      mDis[k] = 1'b0;
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int unsigned lens [4] = '{1, 2, 4, 8};
    int seq = 0;
    for (int k = 0; k < 3; k++) begin
      mCtl[k] = '0; mAddr[k] = '0; mData[k] = '0; mEn[k] = 0; mDis[k] = 0;
    end
    repeat (3) @(negedge clk);
    checkAll("R11 reset");
    rst_n = 1'b1;

    // Sweep every start address around the window with every length
    for (int pass = 0; pass < 2; pass++)
      for (int a = OFF - 4; a <= OFF + 28; a++)
        for (int li = 0; li < 4; li++) begin
          logic [63:0] d = 64'h0123_4567_89AB_CDEF ^ (64'(seq) * 64'h9E37_79B9_7F4A_7C15);
          seq++;
          doWrite(a, lens[li], d, "sweep R1");
        end

    // Directed cases
    doWrite(OFF + 2, 2, 64'h0000_0000_0000_0001, "R3 enable set");
    doWrite(OFF + 2, 2, 64'h0000_0000_0000_0001, "R3 enable hold");
    doWrite(OFF + 2, 2, 64'h0000_0000_0000_0000, "R3 disable");
    doWrite(OFF + 4, 8, 64'h8877_6655_4433_2211, "R6 full address");
    chk("R6 R8 byte order", 0, oAddr[0], 64'h8877_6655_4433_2211);
    doWrite(OFF + 8, 4, 64'h0000_0000_DDCC_BBAA, "R5 high half");
    chk("R5 R8 high half", 0, oAddr[0], 64'hDDCC_BBAA_4433_2211);
    doWrite(OFF + 4, 4, 64'h0000_0000_1234_5678, "R4 low half");
    chk("R4 32-bit clears upper", 1, oAddr[1], 64'h0000_0000_1234_5678);
    chk("R5 64-bit keeps upper", 0, oAddr[0], 64'hDDCC_BBAA_1234_5678);
    doWrite(OFF - 1, 2, 64'h0000_0000_0000_FFFF, "R1 straddle start");
    doWrite(OFF + 2, 1, 64'h0000_0000_0000_00FF, "R9 one-byte ctrl");
    chk("R9 ctrl unchanged", 0, 64'(oCtl[0]), 64'h0);
    doWrite(OFF + 12, 4, 64'h0000_0000_FFFF_FFFF, "R9 wide data");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule